// File: doc/BRIEF.md
# Debug Mode Entry and Redirect Controller

This block sits beside the decode stage of a processor core and decides, every cycle, whether the core must enter Debug Mode, take an ebreak trap, or be sent to one of the debugger's fixed addresses. It takes three kinds of input. The first is a synchronous halt request from the debug module. The second is a trigger-match flag for the instruction in decode. The third is a set of decoded events for that instruction: ebreak, exception, mret, uret and dret. From these it produces a same-cycle PC redirect with its target, a kill for the instruction in decode, and write strobes for the saved debug PC and the cause field.

The block also holds the debug-mode flag and the debug register set: the control/status register, the saved PC and two scratch registers. Software accesses these through a simple CSR port, and only Debug Mode is allowed to touch them. The way ebreak is handled depends on the debug-mode flag and the ebreakm control bit. Inside Debug Mode, every control transfer goes to a fixed debugger address and leaves the registers alone.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, `dbg_mode_o` and `ebreakm_o` are 0, no redirect or write strobe is active, and the saved PC and cause read back as 0.
- R2: Outside Debug Mode, a high `halt_req_i` makes the following happen in the same cycle: `redirect_o`, `kill_dec_o`, `dpc_we_o` and `dcause_we_o` are raised, and `redirect_pc_o` is the halt address. On the next clock `dbg_mode_o` is 1, the saved PC (CSR 0x7B1) holds `dec_pc_i` with bit 0 cleared, and the cause field (bits 8:6 of CSR 0x7B0) reads 3. This applies even when `dec_valid_i` is 0.
- R3: Outside Debug Mode, `trig_hit_i` together with `dec_valid_i` causes the same entry as R2, with cause 2.
- R4: Outside Debug Mode, a valid ebreak while ebreakm is 1 causes the same entry as R2, with cause 1.
- R5: When several entry causes are present at once, trigger wins over ebreak, and ebreak wins over the halt request. A halt request also wins over an ebreak trap.
- R6: Outside Debug Mode, a valid ebreak while ebreakm is 0 redirects to the machine trap vector and raises `mepc_we_o` and `mcause_we_o`. No debug strobe, no kill, and `dbg_mode_o` stays 0.
- R7: Inside Debug Mode, a valid ebreak with no exception, mret or uret redirects to the halt address. No write strobe is raised, and the saved PC and cause are unchanged.
- R8: Inside Debug Mode, a valid exception, mret or uret redirects to the debug exception address. This has priority over ebreak and dret. No strobe is raised and the registers are unchanged.
- R9: Inside Debug Mode, `halt_req_i` and `trig_hit_i` have no effect: no kill, no strobe, and the saved PC and cause are unchanged.
- R10: Outside Debug Mode, any access to CSR 0x7B0 to 0x7B3 sets `csr_illegal_o`, reads 0, and has no effect on the stored values.
- R11: Inside Debug Mode, writing CSR 0x7B0 updates only ebreakm (bit 15); the cause field is read-only. The saved PC and the scratch registers (0x7B2, 0x7B3) are readable and writable, and bit 0 of the saved PC is always 0.
- R12: Inside Debug Mode, a valid dret that no higher-priority event pre-empts redirects to the saved PC and clears `dbg_mode_o` on the next clock.
- R13: Halt, debug exception and trap-vector targets always have their two low bits forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Synchronous halt request from the debug module |
| trig_hit_i | input | 1 | Trigger matched the instruction in decode |
| dec_valid_i | input | 1 | Instruction in decode is valid |
| dec_ebreak_i | input | 1 | Decoded ebreak |
| dec_exc_i | input | 1 | Decoded instruction raises an exception |
| dec_mret_i | input | 1 | Decoded mret |
| dec_uret_i | input | 1 | Decoded uret |
| dec_dret_i | input | 1 | Decoded dret |
| dec_pc_i | input | XLEN | PC of the instruction in decode |
| halt_addr_i | input | XLEN | Debugger entry address |
| exc_addr_i | input | XLEN | Debugger exception address |
| mtvec_i | input | XLEN | Machine trap vector |
| csr_req_i | input | 1 | CSR access request |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| csr_illegal_o | output | 1 | Access to a debug CSR outside Debug Mode |
| redirect_o | output | 1 | PC redirect request |
| redirect_pc_o | output | XLEN | Redirect target |
| kill_dec_o | output | 1 | Suppress the instruction in decode |
| dpc_we_o | output | 1 | Saved debug PC is written this cycle |
| dcause_we_o | output | 1 | Debug cause is written this cycle |
| dcause_o | output | 3 | Cause value being written |
| mepc_we_o | output | 1 | Machine exception PC write for ebreak trap |
| mcause_we_o | output | 1 | Machine cause write for ebreak trap |
| dbg_mode_o | output | 1 | Core is in Debug Mode |
| ebreakm_o | output | 1 | Current ebreakm control bit |

## Verification
A debug-mode flag that is stuck or set wrongly shows up at the ports in the same cycle. The next event then produces the wrong redirect target or a missing kill. CSR accesses also flip their illegal flag on the very next read. A corrupted saved PC or cause is invisible until something reads it back, or until the next dret, whose redirect target exposes the stored PC at once. Because of this, every entry in the sweeps is followed by a read-back of the saved PC and cause, and every exit goes through dret with its target checked.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_EBREAK  = 3'd1,
    CAUSE_TRIGGER = 3'd2,
    CAUSE_HALTREQ = 3'd3
  } dbg_cause_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ENTER,
    ACT_TRAP,
    ACT_RESTART,
    ACT_DEXC,
    ACT_RESUME
  } dbg_action_e;

endpackage

// File: rtl/dbg_entry_arbiter.sv
module dbg_entry_arbiter
  import dbg_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            dbg_mode,
  input  logic            ebreakm,
  input  logic            halt_req,
  input  logic            trig_hit,
  input  logic            dec_valid,
  input  logic            dec_ebreak,
  input  logic            dec_exc,
  input  logic            dec_xret,
  input  logic            dec_dret,
  input  logic [XLEN-1:0] halt_addr,
  input  logic [XLEN-1:0] exc_addr,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] dpc,
  output dbg_action_e     action,
  output dbg_cause_e      cause,
  output logic [XLEN-1:0] target
);

  localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);

  // decision: entry causes ranked trigger > ebreak > halt request > trap
  always_comb begin
    action = ACT_NONE;
    cause  = CAUSE_NONE;
    if (!dbg_mode) begin
      if (dec_valid && trig_hit) begin
        action = ACT_ENTER;
        cause  = CAUSE_TRIGGER;
      end else if (dec_valid && dec_ebreak && ebreakm) begin
        action = ACT_ENTER;
        cause  = CAUSE_EBREAK;
      end else if (halt_req) begin
        action = ACT_ENTER;
        cause  = CAUSE_HALTREQ;
      end else if (dec_valid && dec_ebreak) begin
        action = ACT_TRAP;
      end
    end else if (dec_valid) begin
      if (dec_exc || dec_xret) action = ACT_DEXC;
      else if (dec_ebreak)     action = ACT_RESTART;
      else if (dec_dret)       action = ACT_RESUME;
    end
  end

  always_comb begin
    unique case (action)
      ACT_ENTER, ACT_RESTART: target = halt_addr & WORD_MASK;
      ACT_DEXC:               target = exc_addr & WORD_MASK;
      ACT_TRAP:               target = mtvec & WORD_MASK;
      ACT_RESUME:             target = dpc;
      default:                target = '0;
    endcase
  end

endmodule

// File: rtl/dbg_mode_flag.sv
module dbg_mode_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic mode_o
);

  logic mode_d, mode_q;

  always_comb begin
    mode_d = mode_q;
    if (set_i)      mode_d = 1'b1;
    else if (clr_i) mode_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/dbg_csr_file.sv
module dbg_csr_file
  import dbg_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          N_SCRATCH  = 2,
  parameter logic [11:0] ADDR_CTRL  = 12'h7B0,
  parameter logic [11:0] ADDR_DPC   = 12'h7B1,
  parameter logic [11:0] ADDR_SCR0  = 12'h7B2,
  parameter logic [3:0]  DBG_VER    = 4'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_mode,
  input  logic            hw_we,
  input  dbg_cause_e      hw_cause,
  input  logic [XLEN-1:0] hw_pc,
  input  logic            csr_req,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic            ebreakm,
  output logic [XLEN-1:0] dpc
);

  localparam logic [XLEN-1:0] HALF_MASK = ~XLEN'(1);
  localparam int              EBM_BIT   = 15;

  logic sel_ctrl, sel_dpc, hit, sw_wr;
  logic [N_SCRATCH-1:0] sel_scr;

  always_comb begin
    sel_ctrl = (csr_addr == ADDR_CTRL);
    sel_dpc  = (csr_addr == ADDR_DPC);
    hit      = sel_ctrl | sel_dpc | (|sel_scr);
  end

  assign csr_illegal = csr_req & hit & ~dbg_mode;
  assign sw_wr       = csr_req & csr_we & dbg_mode;

  // control/status: only ebreakm is writable, cause is set by hardware
  logic       ebm_d, ebm_q;
  dbg_cause_e cause_d, cause_q;
  logic [XLEN-1:0] dpc_d, dpc_q;

  always_comb begin
    ebm_d   = ebm_q;
    cause_d = cause_q;
    dpc_d   = dpc_q;
    if (sw_wr && sel_ctrl) ebm_d = csr_wdata[EBM_BIT];
    if (hw_we) begin
      cause_d = hw_cause;
      dpc_d   = hw_pc & HALF_MASK;
    end else if (sw_wr && sel_dpc) begin
      dpc_d   = csr_wdata & HALF_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ebm_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      dpc_q   <= '0;
    end else begin
      ebm_q   <= ebm_d;
      cause_q <= cause_d;
      dpc_q   <= dpc_d;
    end
  end

  // scratch registers, one per generate slot
  logic [XLEN-1:0] scr_q [N_SCRATCH];

  for (genvar g = 0; g < N_SCRATCH; g++) begin : g_scr
    logic [XLEN-1:0] scr_d;
    assign sel_scr[g] = (csr_addr == ADDR_SCR0 + 12'(g));
    always_comb begin
      scr_d = scr_q[g];
      if (sw_wr && sel_scr[g]) scr_d = csr_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scr_q[g] <= '0;
      else        scr_q[g] <= scr_d;
    end
  end

  logic [31:0] ctrl_word;
  assign ctrl_word = {DBG_VER, 12'h0, ebm_q, 6'h0, cause_q, 4'h0, 2'b11};

  always_comb begin
    csr_rdata = '0;
    if (csr_req && dbg_mode) begin
      if (sel_ctrl) csr_rdata = XLEN'(ctrl_word);
      if (sel_dpc)  csr_rdata = dpc_q;
      for (int i = 0; i < N_SCRATCH; i++)
        if (sel_scr[i]) csr_rdata = scr_q[i];
    end
  end

  assign ebreakm = ebm_q;
  assign dpc     = dpc_q;

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int N_SCRATCH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req_i,
  input  logic            trig_hit_i,
  input  logic            dec_valid_i,
  input  logic            dec_ebreak_i,
  input  logic            dec_exc_i,
  input  logic            dec_mret_i,
  input  logic            dec_uret_i,
  input  logic            dec_dret_i,
  input  logic [XLEN-1:0] dec_pc_i,
  input  logic [XLEN-1:0] halt_addr_i,
  input  logic [XLEN-1:0] exc_addr_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic            csr_req_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            kill_dec_o,
  output logic            dpc_we_o,
  output logic            dcause_we_o,
  output logic [2:0]      dcause_o,
  output logic            mepc_we_o,
  output logic            mcause_we_o,
  output logic            dbg_mode_o,
  output logic            ebreakm_o
);

  dbg_action_e     action;
  dbg_cause_e      cause;
  logic [XLEN-1:0] dpc;
  logic            dbg_mode, ebreakm, enter;

  dbg_entry_arbiter #(.XLEN(XLEN)) u_arb (
    .dbg_mode   (dbg_mode),
    .ebreakm    (ebreakm),
    .halt_req   (halt_req_i),
    .trig_hit   (trig_hit_i),
    .dec_valid  (dec_valid_i),
    .dec_ebreak (dec_ebreak_i),
    .dec_exc    (dec_exc_i),
    .dec_xret   (dec_mret_i | dec_uret_i),
    .dec_dret   (dec_dret_i),
    .halt_addr  (halt_addr_i),
    .exc_addr   (exc_addr_i),
    .mtvec      (mtvec_i),
    .dpc        (dpc),
    .action     (action),
    .cause      (cause),
    .target     (redirect_pc_o)
  );

  assign enter = (action == ACT_ENTER);

  dbg_mode_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (enter),
    .clr_i  (action == ACT_RESUME),
    .mode_o (dbg_mode)
  );

  dbg_csr_file #(.XLEN(XLEN), .N_SCRATCH(N_SCRATCH)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_mode    (dbg_mode),
    .hw_we       (enter),
    .hw_cause    (cause),
    .hw_pc       (dec_pc_i),
    .csr_req     (csr_req_i),
    .csr_we      (csr_we_i),
    .csr_addr    (csr_addr_i),
    .csr_wdata   (csr_wdata_i),
    .csr_rdata   (csr_rdata_o),
    .csr_illegal (csr_illegal_o),
    .ebreakm     (ebreakm),
    .dpc         (dpc)
  );

  assign redirect_o  = (action != ACT_NONE);
  assign kill_dec_o  = enter;
  assign dpc_we_o    = enter;
  assign dcause_we_o = enter;
  assign dcause_o    = cause;
  assign mepc_we_o   = (action == ACT_TRAP);
  assign mcause_we_o = (action == ACT_TRAP);
  assign dbg_mode_o  = dbg_mode;
  assign ebreakm_o   = ebreakm;

endmodule

// File: rtl/dbg_entry_checker.sv
module dbg_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dbg_mode_o,
  input logic            dpc_we_o,
  input logic            dcause_we_o,
  input logic [2:0]      dcause_o,
  input logic            kill_dec_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            mepc_we_o,
  input logic            csr_req_i,
  input logic [11:0]     csr_addr_i,
  input logic            csr_illegal_o,
  input logic            dec_valid_i,
  input logic            dec_ebreak_i,
  input logic            dec_exc_i,
  input logic            dec_mret_i,
  input logic            dec_uret_i,
  input logic            dec_dret_i
);

  a_r2_entry_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    dpc_we_o |=> dbg_mode_o);

  a_r2_entry_kills: assert property (@(posedge clk) disable iff (!rst_n)
    dpc_we_o |-> (kill_dec_o && redirect_o && dcause_we_o));

  a_r5_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
    dcause_we_o |-> (dcause_o inside {3'd1, 3'd2, 3'd3}));

  a_r6_trap_stays_out: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we_o |=> !dbg_mode_o);

  a_r7_no_strobe_in_debug: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode_o |-> (!dpc_we_o && !dcause_we_o && !mepc_we_o && !kill_dec_o));

  a_r10_illegal_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && csr_addr_i[11:2] == 10'h1EC && !dbg_mode_o) |-> csr_illegal_o);

  a_r12_dret_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_o && dec_valid_i && dec_dret_i && !dec_ebreak_i && !dec_exc_i
     && !dec_mret_i && !dec_uret_i) |=> !dbg_mode_o);

  a_r13_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (dpc_we_o || mepc_we_o) |-> (redirect_pc_o[1:0] == 2'b00));

endmodule

bind dbg_entry_ctrl dbg_entry_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/dbg_entry_ctrl_test.sv
module dbg_entry_ctrl_test;

  localparam int XLEN = 32;
  localparam logic [11:0] A_CTRL = 12'h7B0, A_DPC = 12'h7B1,
                          A_SCR0 = 12'h7B2, A_SCR1 = 12'h7B3;
  localparam logic [31:0] HALT_A = 32'h8000_0803, EXC_A = 32'h8000_0A07,
                          MTVEC  = 32'h0000_0102, P0 = 32'h0000_4006;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_req, trig_hit, dec_valid, dec_ebreak, dec_exc, dec_mret, dec_uret, dec_dret;
  logic [31:0] dec_pc, halt_addr, exc_addr, mtvec, csr_wdata, csr_rdata, redirect_pc;
  logic csr_req, csr_we, csr_illegal, redirect, kill, dpc_we, dcause_we;
  logic mepc_we, mcause_we, dbg_mode, ebreakm;
  logic [11:0] csr_addr;
  logic [2:0] dcause;

  int checks = 0, fails = 0;
  logic [31:0] rd;
  logic ill;

  always #5 clk = ~clk;

  dbg_entry_ctrl #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req), .trig_hit_i(trig_hit),
    .dec_valid_i(dec_valid), .dec_ebreak_i(dec_ebreak), .dec_exc_i(dec_exc),
    .dec_mret_i(dec_mret), .dec_uret_i(dec_uret), .dec_dret_i(dec_dret),
    .dec_pc_i(dec_pc), .halt_addr_i(halt_addr), .exc_addr_i(exc_addr), .mtvec_i(mtvec),
    .csr_req_i(csr_req), .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .csr_illegal_o(csr_illegal), .redirect_o(redirect),
    .redirect_pc_o(redirect_pc), .kill_dec_o(kill), .dpc_we_o(dpc_we),
    .dcause_we_o(dcause_we), .dcause_o(dcause), .mepc_we_o(mepc_we),
    .mcause_we_o(mcause_we), .dbg_mode_o(dbg_mode), .ebreakm_o(ebreakm)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    halt_req = 0; trig_hit = 0; dec_valid = 0; dec_ebreak = 0; dec_exc = 0;
    dec_mret = 0; dec_uret = 0; dec_dret = 0; csr_req = 0; csr_we = 0;
    csr_addr = '0; csr_wdata = '0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d, output logic il);
    @(negedge clk);
    csr_req = 1; csr_we = 0; csr_addr = a;
    #1 d = csr_rdata; il = csr_illegal;
    csr_req = 0;
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_req = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_req = 0; csr_we = 0;
  endtask

  task automatic enter_halt(input logic [31:0] pc);
    @(negedge clk);
    halt_req = 1; dec_pc = pc;
    @(negedge clk);
    halt_req = 0;
  endtask

  task automatic dret_pulse();
    @(negedge clk);
    dec_valid = 1; dec_dret = 1;
    @(negedge clk);
    dec_valid = 0; dec_dret = 0;
  endtask

  task automatic set_ebm(input logic b);
    enter_halt(P0);
    csr_write(A_CTRL, {16'h0, b, 15'h0});
    dret_pulse();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    dec_pc = P0; halt_addr = HALT_A; exc_addr = EXC_A; mtvec = MTVEC;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 mode", {31'h0, dbg_mode}, 0);
    check("R1 ebreakm", {31'h0, ebreakm}, 0);
    check("R1 redirect", {31'h0, redirect}, 0);
    rst_n = 1;

    // R10 outside Debug Mode: illegal, read 0, writes ignored
    csr_write(A_CTRL, 32'h0000_8000);
    csr_write(A_DPC, 32'h1234_5678);
    csr_write(A_SCR1, 32'hDEAD_BEEF);
    for (int a = 0; a < 4; a++) begin
      csr_read(A_CTRL + 12'(a), rd, ill);
      check("R10 illegal", {31'h0, ill}, 1);
      check("R10 rdata", rd, 0);
    end
    check("R10 ebreakm untouched", {31'h0, ebreakm}, 0);
    enter_halt(P0);
    csr_read(A_SCR1, rd, ill);
    check("R10 scratch untouched", rd, 0);
    check("R10 legal in debug", {31'h0, ill}, 0);

    // R11 register access in Debug Mode
    csr_write(A_CTRL, 32'h0000_81C0);
    csr_read(A_CTRL, rd, ill);
    check("R11 ebreakm bit", {31'h0, rd[15]}, 1);
    check("R11 cause read-only", {29'h0, rd[8:6]}, 3);
    csr_write(A_CTRL, 32'h0);
    csr_write(A_SCR0, 32'hA5A5_0001);
    csr_write(A_SCR1, 32'h5A5A_0002);
    csr_read(A_SCR0, rd, ill); check("R11 scratch0", rd, 32'hA5A5_0001);
    csr_read(A_SCR1, rd, ill); check("R11 scratch1", rd, 32'h5A5A_0002);
    csr_write(A_DPC, 32'h0000_2345);
    csr_read(A_DPC, rd, ill); check("R11 dpc bit0", rd, 32'h0000_2344);
    // R12 dret goes to written DPC
    @(negedge clk);
    dec_valid = 1; dec_dret = 1;
    #1 check("R12 redirect", {31'h0, redirect}, 1);
    check("R12 target", redirect_pc, 32'h0000_2344);
    @(negedge clk);
    dec_valid = 0; dec_dret = 0;
    #1 check("R12 mode cleared", {31'h0, dbg_mode}, 0);

    // R2..R6, R13: sweep outside Debug Mode
    for (int m = 0; m < 32; m++) begin
      logic h, t, e, v, b, ent, trp;
      logic [31:0] pc, tgt;
      logic [2:0] c;
      h = m[0]; t = m[1]; e = m[2]; v = m[3]; b = m[4];
      pc = 32'h0000_1000 + 32'(m * 6);
      set_ebm(b);
      ent = (v & t) | (v & e & b) | h;
      trp = !ent & v & e;
      c = (v & t) ? 3'd2 : (v & e & b) ? 3'd1 : 3'd3;
      tgt = ent ? 32'h8000_0800 : 32'h0000_0100;
      @(negedge clk);
      halt_req = h; trig_hit = t; dec_ebreak = e; dec_valid = v; dec_pc = pc;
      #1;
      check("R5 redirect", {31'h0, redirect}, {31'h0, ent | trp});
      if (ent | trp) check("R13 target", redirect_pc, tgt);
      check("R2 kill", {31'h0, kill}, {31'h0, ent});
      check("R2 dpc_we", {31'h0, dpc_we}, {31'h0, ent});
      check("R6 mepc_we", {31'h0, mepc_we}, {31'h0, trp});
      check("R6 mcause_we", {31'h0, mcause_we}, {31'h0, trp});
      if (ent) check("R5 cause", {29'h0, dcause}, {29'h0, c});
      @(negedge clk);
      idle();
      #1 check("R6 mode", {31'h0, dbg_mode}, {31'h0, ent});
      if (ent) begin
        csr_read(A_DPC, rd, ill);
        check("R2 saved pc", rd, pc & 32'hFFFF_FFFE);
        csr_read(A_CTRL, rd, ill);
        check("R3 R4 cause", {29'h0, rd[8:6]}, {29'h0, c});
        dret_pulse();
      end
    end

    // R7 R8 R9 R12: sweep inside Debug Mode with halt and trigger held high
    set_ebm(1'b0);
    enter_halt(P0);
    for (int m = 0; m < 64; m++) begin
      logic v, e, x, mr, ur, dr, red, res;
      logic [31:0] tgt;
      v = m[0]; e = m[1]; x = m[2]; mr = m[3]; ur = m[4]; dr = m[5];
      red = 1'b1; res = 1'b0; tgt = 32'h0;
      if (v && (x || mr || ur))  tgt = 32'h8000_0A04;
      else if (v && e)           tgt = 32'h8000_0800;
      else if (v && dr) begin    tgt = P0 & 32'hFFFF_FFFE; res = 1'b1; end
      else                       red = 1'b0;
      @(negedge clk);
      halt_req = 1; trig_hit = 1; dec_valid = v; dec_ebreak = e; dec_exc = x;
      dec_mret = mr; dec_uret = ur; dec_dret = dr; dec_pc = 32'h0000_7770;
      #1;
      check("R8 redirect", {31'h0, redirect}, {31'h0, red});
      if (red) check("R8 target", redirect_pc, tgt);
      check("R9 no kill", {31'h0, kill}, 0);
      check("R7 no strobe", {29'h0, dpc_we, dcause_we, mepc_we}, 0);
      @(negedge clk);
      idle();
      #1 check("R12 mode", {31'h0, dbg_mode}, {31'h0, !res});
      if (res) enter_halt(P0);
      csr_read(A_DPC, rd, ill);
      check("R7 dpc kept", rd, P0 & 32'hFFFF_FFFE);
      csr_read(A_CTRL, rd, ill);
      check("R9 cause kept", {29'h0, rd[8:6]}, 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule